// File: doc/BRIEF.md
# Converter Control Word Register

This block is the control word of a four-channel converter, written and read through the device's serial register port. The word holds a range bit for each channel, a power-down bit for each of the two channel groups, a bit that silences the serial data output, and two bits that control open-drain general-purpose pins. It also has two action bits. One produces a single-cycle load strobe toward the channel register bank. The other produces a software reset that returns the word to its power-on state. Both action bits clear themselves and always read back as 0.

Each channel group has a ready flag. The flag drops while the group's power-down bit is set. It rises again only after a fixed wake delay, counted in system clocks, has passed since the bit was cleared. On a read, the pin-control bits return the level sampled on the pins, not the value that was written. A 1 written to a pin-control bit releases the pin so that it can serve as an input.

Top module: `dac_cmd_reg`

## Requirements
- R1: After a synchronous reset, every range bit is 1, both pin bits are 1 (no pin driven low), both power-down bits are 0, the silence bit is 0, both ready flags are 1 and both strobes are low. With both pins high, a read returns 0x003F.
- R2: The word layout is: bits [1:0] pin control (bit 0 is pin 0), bits [5:2] range (bit 2 is channel 0), bits [7:6] power-down (bit 6 is group 0, which holds channels 0 and 1), bit 8 silence, bit 9 load, bit 10 software reset. A write with bits 9 and 10 both 0 stores bits [8:0], and `sdo_off` follows bit 8.
- R3: `gpio_drive_low[i]` is 1 exactly when pin bit i holds 0. On a read, bits [1:0] return `gpio_in`, whatever value was written.
- R4: A write with bit 9 set and bit 10 clear raises `load_pulse` for exactly the one cycle after the write. Bit 9 reads back as 0.
- R5: A write with bit 10 set restores the R1 field values and ignores every other bit in that write, including bit 9. It raises `srst_pulse` for exactly one cycle after the write, and bit 10 reads back as 0.
- R6: While a group's power-down bit is 1, `grp_pd` for that group is 1 and its ready flag is 0. The other group's flag and all other fields are not affected.
- R7: After a group's power-down bit goes from 1 to 0, its ready flag rises exactly WAKE_CYCLES clocks later and not earlier.
- R8: Written values in bits [15:11] are ignored, and those bits read back as 0.
- R9: `gain_x4[c]` equals range bit c (1 = ×4, 0 = ×2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Write strobe from the serial register port |
| wr_data | input | 16 | Word to write |
| rd_data | output | 16 | Current word as read back |
| gpio_in | input | 2 | Sampled level on each general-purpose pin |
| gpio_drive_low | output | 2 | Enable for each pin's pull-down driver |
| gain_x4 | output | 4 | Range selection for each channel |
| grp_pd | output | 2 | Power-down command for each group |
| grp_ready | output | 2 | Group output stage settled |
| sdo_off | output | 1 | Disables the serial data output driver |
| load_pulse | output | 1 | One-cycle strobe that loads the channel registers |
| srst_pulse | output | 1 | One-cycle software reset strobe |

## Verification
The hardest case to reach from the ports is the exact wake edge. The ready flag depends on the registered power-down bit and on a counter that cannot be seen. The stimulus sets group 0's power-down bit, confirms that group 1 is unaffected, and then clears the bit with a second write. The bench then samples the flag one clock before and one clock at the WAKE_CYCLES point. A second hard case is a single write that requests both software reset and load, which shows that the reset takes priority.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
    parameter int unsigned NUM_CH  = 4;
    parameter int unsigned NUM_GRP = 2;
    parameter int unsigned NUM_PIN = 2;
    parameter int unsigned WORD_W  = 16;

    localparam int unsigned PIN_LSB   = 0;
    localparam int unsigned GAIN_LSB  = PIN_LSB + NUM_PIN;
    localparam int unsigned PD_LSB    = GAIN_LSB + NUM_CH;
    localparam int unsigned QUIET_BIT = PD_LSB + NUM_GRP;
    localparam int unsigned LOAD_BIT  = QUIET_BIT + 1;
    localparam int unsigned SRST_BIT  = LOAD_BIT + 1;

    typedef struct packed {
        logic               quiet;
        logic [NUM_GRP-1:0] pd;
        logic [NUM_CH-1:0]  gain;
        logic [NUM_PIN-1:0] pin_rel;
    } ctrl_t;

    function automatic ctrl_t ctrl_default();
        ctrl_t c;
        c.quiet   = 1'b0;
        c.pd      = '0;
        c.gain    = '1;
        c.pin_rel = '1;
        return c;
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [WORD_W-1:0] w);
        ctrl_t c;
        c.quiet   = w[QUIET_BIT];
        c.pd      = w[PD_LSB +: NUM_GRP];
        c.gain    = w[GAIN_LSB +: NUM_CH];
        c.pin_rel = w[PIN_LSB +: NUM_PIN];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_pack(ctrl_t c, logic [NUM_PIN-1:0] pins);
        logic [WORD_W-1:0] w;
        w = '0;
        w[QUIET_BIT]          = c.quiet;
        w[PD_LSB +: NUM_GRP]  = c.pd;
        w[GAIN_LSB +: NUM_CH] = c.gain;
        w[PIN_LSB +: NUM_PIN] = pins;
        return w;
    endfunction
endpackage

// File: rtl/cmdreg_fields.sv
module cmdreg_fields
    import cmdreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic              load_pulse,
    output logic              srst_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= ctrl_default();
            load_pulse <= 1'b0;
            srst_pulse <= 1'b0;
        end else begin
            load_pulse <= 1'b0;
            srst_pulse <= 1'b0;
            if (wr_en) begin
                if (wr_data[SRST_BIT]) begin
                    ctrl       <= ctrl_default();
                    srst_pulse <= 1'b1;
                end else begin
                    ctrl       <= ctrl_unpack(wr_data);
                    load_pulse <= wr_data[LOAD_BIT];
                end
            end
        end
    end
endmodule

// File: rtl/cmdreg_wake.sv
module cmdreg_wake #(
    parameter int unsigned WAKE_CYCLES = 6250
) (
    input  logic clk,
    input  logic rst,
    input  logic pd,
    output logic ready
);
    localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          settled;

    always_ff @(posedge clk) begin
        if (rst) begin
            settled <= 1'b1;
            cnt     <= '0;
        end else if (pd) begin
            settled <= 1'b0;
            cnt     <= '0;
        end else if (!settled) begin
            if (cnt == CW'(WAKE_CYCLES - 1)) settled <= 1'b1;
            else                             cnt     <= cnt + 1'b1;
        end
    end

    assign ready = settled & ~pd;
endmodule

// File: rtl/cmdreg_pad.sv
module cmdreg_pad
    import cmdreg_pkg::*;
(
    input  logic [NUM_PIN-1:0] pin_rel,
    output logic [NUM_PIN-1:0] drive_low
);
    for (genvar i = 0; i < NUM_PIN; i++) begin : g_pin
        assign drive_low[i] = ~pin_rel[i];
    end
endmodule

// File: rtl/dac_cmd_reg.sv
module dac_cmd_reg
    import cmdreg_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = 6250
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [WORD_W-1:0]  rd_data,
    input  logic [NUM_PIN-1:0] gpio_in,
    output logic [NUM_PIN-1:0] gpio_drive_low,
    output logic [NUM_CH-1:0]  gain_x4,
    output logic [NUM_GRP-1:0] grp_pd,
    output logic [NUM_GRP-1:0] grp_ready,
    output logic               sdo_off,
    output logic               load_pulse,
    output logic               srst_pulse
);
    ctrl_t ctrl;

    cmdreg_fields u_fields (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ctrl       (ctrl),
        .load_pulse (load_pulse),
        .srst_pulse (srst_pulse)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        cmdreg_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
            .clk   (clk),
            .rst   (rst),
            .pd    (ctrl.pd[g]),
            .ready (grp_ready[g])
        );
    end

    cmdreg_pad u_pad (
        .pin_rel   (ctrl.pin_rel),
        .drive_low (gpio_drive_low)
    );

    assign gain_x4 = ctrl.gain;
    assign grp_pd  = ctrl.pd;
    assign sdo_off = ctrl.quiet;
    assign rd_data = ctrl_pack(ctrl, gpio_in);
endmodule

// File: rtl/cmdreg_chk.sv
module cmdreg_chk
    import cmdreg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [WORD_W-1:0]  wr_data,
    input logic [NUM_PIN-1:0] gpio_drive_low,
    input logic [NUM_CH-1:0]  gain_x4,
    input logic [NUM_GRP-1:0] grp_pd,
    input logic [NUM_GRP-1:0] grp_ready,
    input logic               load_pulse,
    input logic               srst_pulse
);
    AST_HW_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gain_x4 == '1 && grp_pd == '0 && grp_ready == '1 && gpio_drive_low == '0)); // R1

    AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> $past(wr_en && wr_data[LOAD_BIT] && !wr_data[SRST_BIT])); // R4

    AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        srst_pulse |-> (gain_x4 == '1 && grp_pd == '0 && gpio_drive_low == '0 && !load_pulse)); // R5

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        AST_PD_NOT_READY: assert property (@(posedge clk) disable iff (rst)
            grp_pd[g] |-> !grp_ready[g]); // R6

        AST_READY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
            $rose(grp_ready[g]) |-> (!grp_pd[g] && $past(!grp_pd[g]))); // R7
    end
endmodule

bind dac_cmd_reg cmdreg_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .gpio_drive_low (gpio_drive_low),
    .gain_x4        (gain_x4),
    .grp_pd         (grp_pd),
    .grp_ready      (grp_ready),
    .load_pulse     (load_pulse),
    .srst_pulse     (srst_pulse)
);

// File: tb/sim_dac_cmd_reg.sv
module sim_dac_cmd_reg;
    localparam int WAKE = 40;
    localparam int NV   = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [1:0]  gpio_in = 2'b11;
    logic [1:0]  gpio_drive_low;
    logic [3:0]  gain_x4;
    logic [1:0]  grp_pd, grp_ready;
    logic        sdo_off, load_pulse, srst_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dac_cmd_reg #(.WAKE_CYCLES(WAKE)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .gpio_in(gpio_in), .gpio_drive_low(gpio_drive_low), .gain_x4(gain_x4),
        .grp_pd(grp_pd), .grp_ready(grp_ready), .sdo_off(sdo_off),
        .load_pulse(load_pulse), .srst_pulse(srst_pulse)
    );

    // written word, pin levels, expected read, expected pull-down enables
    localparam logic [15:0] V_W   [NV] = '{16'h0000, 16'h003F, 16'h0140, 16'h0095, 16'hF803};
    localparam logic [1:0]  V_PIN [NV] = '{2'b00,    2'b10,    2'b11,    2'b01,    2'b11};
    localparam logic [15:0] V_RD  [NV] = '{16'h0000, 16'h003E, 16'h0143, 16'h0095, 16'h0003};
    localparam logic [1:0]  V_DRV [NV] = '{2'b11,    2'b00,    2'b11,    2'b10,    2'b00};

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        hw_reset();
        gpio_in = 2'b11;
        @(negedge clk);
        // R1 reset state
        chk("R1 read", rd_data, 16'h003F);
        chk("R1 drive", gpio_drive_low, 2'b00);
        chk("R1 gain", gain_x4, 4'hF);
        chk("R1 pd", grp_pd, 2'b00);
        chk("R1 ready", grp_ready, 2'b11);
        chk("R1 strobes", {sdo_off, load_pulse, srst_pulse}, 3'b000);

        // R2 R3 R8 R9 vector table
        for (int i = 0; i < NV; i++) begin
            gpio_in = V_PIN[i];
            wr(V_W[i]);
            chk("R2 R3 R8 read", rd_data, V_RD[i]);
            chk("R3 drive", gpio_drive_low, V_DRV[i]);
            chk("R9 gain", gain_x4, V_W[i][5:2]);
            chk("R2 sdo_off", sdo_off, V_W[i][8]);
        end

        hw_reset();
        gpio_in = 2'b11;

        // R4 load strobe
        wr(16'h023F);
        chk("R4 pulse", load_pulse, 1'b1);
        chk("R4 readback", rd_data, 16'h003F);
        @(negedge clk);
        chk("R4 one cycle", load_pulse, 1'b0);

        // R5 soft reset wins over load and other bits
        wr(16'h0100);
        chk("R5 setup", rd_data, 16'h0103);
        wr(16'h0640);
        chk("R5 pulse", srst_pulse, 1'b1);
        chk("R5 no load", load_pulse, 1'b0);
        chk("R5 defaults", rd_data, 16'h003F);
        chk("R5 drive", gpio_drive_low, 2'b00);
        chk("R5 pd", grp_pd, 2'b00);
        @(negedge clk);
        chk("R5 one cycle", srst_pulse, 1'b0);

        // R6 power-down group 0
        wr(16'h007F);
        chk("R6 pd", grp_pd, 2'b01);
        chk("R6 ready", grp_ready, 2'b10);
        chk("R6 fields", rd_data, 16'h007F);
        repeat (WAKE + 5) @(negedge clk);
        chk("R6 held", grp_ready, 2'b10);

        // R7 wake delay
        wr(16'h003F);
        chk("R7 pd cleared", grp_pd, 2'b00);
        repeat (WAKE - 1) @(negedge clk);
        chk("R7 early", grp_ready, 2'b10);
        @(negedge clk);
        chk("R7 on time", grp_ready, 2'b11);

        finish_run();
    end
endmodule